// File: doc/BRIEF.md
# External Interrupt Request Controller

This block collects interrupt requests from ten external pins and one non-maskable pin. Each pin is brought into the clock domain through a two-flop synchroniser. A rising edge on the synchronised level sets a sticky request flag for that channel. Only software clears a flag, and it does so by writing zero to the flag's bit. A per-channel enable decides whether a latched flag is passed on to the interrupt controller on the request vector. A disabled channel keeps its flag, so software can poll it.

Software reaches the block through a byte-addressed register bus. Flags and enables are split into two banks: channels 0 to 7 in bank 0 and channels 8 and 9 in bank 1. A read that forms the first half of a read-modify-write returns all ones from a flag register. Writing that value back then clears only the bit that software changed to zero. The non-maskable channel has its own latch and output. It has no enable and cannot be reached from the bus. A separate acknowledge input from the CPU side clears it.

Top module: `extint_ctrl`

## Requirements
- R1: After a synchronous reset, every flag, every enable, `irq_req_o` and `nmi_req_o` are 0, and reads of all four registers return 0x00.
- R2: A 0-to-1 transition on a pin sets that channel's flag at the third rising clock edge after the pin changes. A pin that stays high does not set the flag again after it has been cleared.
- R3: Register map. The bank 0 flags are at 0x40 and the bank 0 enables at 0x41, with channel n in bit n. The bank 1 flags are at 0xB8 and the bank 1 enables at 0xB9, with channel 8 in bit 0 and channel 9 in bit 1. A plain read of a flag bit returns 1 while a request is pending.
- R4: `irq_req_o[n]` is 1 exactly when channel n's flag and enable are both 1.
- R5: While a channel's enable is 0, its flag remains set and readable, but its bit of `irq_req_o` stays 0.
- R6: Writing 0 to a flag bit clears that flag at the next clock edge. Writing 1 to a flag bit leaves it unchanged.
- R7: A read of either flag register with `bus_rmw_i` high returns 0xFF.
- R8: If an edge sets a flag in the same cycle that a write clears it, the flag ends up set. Other bits cleared by the same write are still cleared.
- R9: Bits 7 to 2 of the bank 1 enable and flag registers read as 0, whatever is written to them. A read of any unmapped address returns 0x00, and `bus_rdata_o` is 0x00 when `bus_rd_i` is low.
- R10: A rising edge on `nmi_pin_i` sets `nmi_req_o` after the same three-edge delay as R2. Bus writes do not clear it, and bus reads do not show it. A one-cycle `nmi_ack_i` clears it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_i | input | 10 | Asynchronous external interrupt pins, channel n on bit n |
| nmi_pin_i | input | 1 | Asynchronous non-maskable interrupt pin |
| nmi_ack_i | input | 1 | Clears the non-maskable request latch |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, committed at the clock edge |
| bus_rd_i | input | 1 | Read strobe, data returned in the same cycle |
| bus_rmw_i | input | 1 | Marks the read as the read half of a read-modify-write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from address and strobes |
| irq_req_o | output | 10 | Enabled pending requests to the interrupt controller |
| nmi_req_o | output | 1 | Pending non-maskable request |

## Verification
Three results have fixed and different latencies. Read data is combinational, so it is due in the same cycle as the read strobe. A register write takes effect at the next rising edge. A pin edge reaches its flag, and through it `irq_req_o` or `nmi_req_o`, at the third rising edge after the pin changes. The bench changes every input at a falling edge and samples one time unit after that falling edge. After a pin change it waits four edges before it samples. For the set-against-clear collision it places the clearing write exactly in the cycle of the third edge.

// File: rtl/extint_pkg.sv
// Package: shared constants and types for the external interrupt controller.
// Assumes an 8-bit register bus and at most 16 maskable channels.
package extint_pkg;
    localparam int NCH      = 10;          // maskable channels
    localparam int BANK_W   = 8;           // bits per register bank
    localparam int HI_W     = NCH - BANK_W; // channels held in bank 1
    localparam int ADDR_W   = 8;
    localparam int SYNC_N   = 2;           // synchroniser depth

    localparam logic [ADDR_W-1:0] FLAG0_ADDR = 8'h40;
    localparam logic [ADDR_W-1:0] ENBL0_ADDR = 8'h41;
    localparam logic [ADDR_W-1:0] FLAG1_ADDR = 8'hB8;
    localparam logic [ADDR_W-1:0] ENBL1_ADDR = 8'hB9;

    // One-hot register select derived from the bus address
    typedef struct packed {
        logic flag0;
        logic enbl0;
        logic flag1;
        logic enbl1;
    } regsel_t;
endpackage

// File: rtl/extint_edge_sync.sv
// Module: extint_edge_sync
// Brings W asynchronous pins into the clock domain through STAGES flops and
// raises a one-cycle pulse per bit on each 0-to-1 transition of the result.
// Assumes pins are held for at least one clock period between transitions.
module extint_edge_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] sync_q [STAGES];
    logic [W-1:0] last_q;

    // Synchroniser chain plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
            last_q <= '0;
        end else begin
            sync_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
            last_q <= sync_q[STAGES-1];
        end
    end

    // Rising-edge pulse on the synchronised level
    assign rise_o = sync_q[STAGES-1] & ~last_q;

    // R2
    rise_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/extint_req_latch.sv
// Module: extint_req_latch
// A W-bit bank of sticky request flops. A set pulse sets a bit, a clear
// request drops it, and a set beats a clear in the same cycle.
// Assumes set_i comes from single-cycle edge pulses.
module extint_req_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] req_q;

    // Sticky flags: clear first, then set so the set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & ~clr_i) | set_i;
    end

    assign q_o = req_q;

    // R6
    flag_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req_q) & ~req_q & ~$past(clr_i)) == '0));
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((req_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/extint_ctrl.sv
// Module: extint_ctrl (top)
// External interrupt request controller: ten maskable edge-triggered
// channels in two register banks plus one non-maskable channel cleared by
// acknowledge. Register reads are combinational and writes commit at the edge.
// Assumes one bus access per cycle and a synchronous active-low reset.
module extint_ctrl
    import extint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    irq_pin_i,
    input  logic              nmi_pin_i,
    input  logic              nmi_ack_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic              bus_rmw_i,
    input  logic [BANK_W-1:0] bus_wdata_i,
    output logic [BANK_W-1:0] bus_rdata_o,
    output logic [NCH-1:0]    irq_req_o,
    output logic              nmi_req_o
);
    localparam int NPIN = NCH + 1;

    regsel_t       sel;
    logic [NPIN-1:0] rise_all;
    logic [NCH-1:0]  rise_irq;
    logic            rise_nmi;
    logic [NCH-1:0]  clr_vec;
    logic [NCH-1:0]  flag_q;
    logic [NCH-1:0]  enbl_q;

    // Address decode into a one-hot register select
    always_comb begin
        sel.flag0 = (bus_addr_i == FLAG0_ADDR);
        sel.enbl0 = (bus_addr_i == ENBL0_ADDR);
        sel.flag1 = (bus_addr_i == FLAG1_ADDR);
        sel.enbl1 = (bus_addr_i == ENBL1_ADDR);
    end

    extint_edge_sync #(.W(NPIN), .STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({nmi_pin_i, irq_pin_i}),
        .rise_o (rise_all)
    );

    assign rise_irq = rise_all[NCH-1:0];
    assign rise_nmi = rise_all[NCH];

    // Clear-by-zero vector: only bits written as 0 to a flag register clear
    always_comb begin
        clr_vec = '0;
        if (bus_wr_i && sel.flag0) clr_vec[BANK_W-1:0]   = ~bus_wdata_i;
        if (bus_wr_i && sel.flag1) clr_vec[NCH-1:BANK_W] = ~bus_wdata_i[HI_W-1:0];
    end

    extint_req_latch #(.W(NCH)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (rise_irq),
        .clr_i (clr_vec),
        .q_o   (flag_q)
    );

    extint_req_latch #(.W(1)) u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (rise_nmi),
        .clr_i (nmi_ack_i),
        .q_o   (nmi_req_o)
    );

    // Enable registers; reserved bank 1 bits are not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enbl_q <= '0;
        end else if (bus_wr_i) begin
            if (sel.enbl0) enbl_q[BANK_W-1:0]   <= bus_wdata_i;
            if (sel.enbl1) enbl_q[NCH-1:BANK_W] <= bus_wdata_i[HI_W-1:0];
        end
    end

    // Request vector: latched flag gated by its enable
    assign irq_req_o = flag_q & enbl_q;

    // Read multiplexer with all-ones return on read-modify-write of flags
    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            if (sel.flag0)
                bus_rdata_o = bus_rmw_i ? '1 : flag_q[BANK_W-1:0];
            else if (sel.flag1)
                bus_rdata_o = bus_rmw_i ? '1 : {{(BANK_W-HI_W){1'b0}}, flag_q[NCH-1:BANK_W]};
            else if (sel.enbl0)
                bus_rdata_o = enbl_q[BANK_W-1:0];
            else if (sel.enbl1)
                bus_rdata_o = {{(BANK_W-HI_W){1'b0}}, enbl_q[NCH-1:BANK_W]};
        end
    end

    // R4
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_req_o & ~$past(irq_req_o))) |-> ($past(bus_wr_i) || (|$past(rise_irq))));
    // R9
    reserved_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && sel.enbl1) |-> (bus_rdata_o[BANK_W-1:HI_W] == '0));
    // R10
    nmi_clear_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_req_o) |-> $past(nmi_ack_i));
    // R7
    rmw_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_rmw_i && (sel.flag0 || sel.flag1)) |-> (bus_rdata_o == '1));
endmodule

// File: tb/tb_extint_ctrl.sv
// Bench for extint_ctrl: a table walk of register, pin and output steps,
// followed by directed tests for collision, non-maskable channel and reset.
module tb_extint_ctrl;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_WR  = 3'd0;
    localparam logic [2:0] OP_RD  = 3'd1;
    localparam logic [2:0] OP_RMW = 3'd2;
    localparam logic [2:0] OP_PIN = 3'd3;
    localparam logic [2:0] OP_IRQ = 3'd4;

    // {req[3:0], op[2:0], addr[7:0], data[9:0], exp[9:0]}
    localparam int NV = 29;
    localparam logic [34:0] VEC [NV] = '{
        {4'd1,  OP_RD,  8'h40, 10'h000, 10'h000},  // R1
        {4'd1,  OP_RD,  8'h41, 10'h000, 10'h000},  // R1
        {4'd1,  OP_IRQ, 8'h00, 10'h000, 10'h000},  // R1
        {4'd2,  OP_PIN, 8'h00, 10'h001, 10'h000},  // R2 ch0 rises
        {4'd3,  OP_RD,  8'h40, 10'h000, 10'h001},  // R3
        {4'd5,  OP_IRQ, 8'h00, 10'h000, 10'h000},  // R5 disabled
        {4'd4,  OP_WR,  8'h41, 10'h001, 10'h000},  // R4
        {4'd4,  OP_IRQ, 8'h00, 10'h000, 10'h001},  // R4
        {4'd2,  OP_PIN, 8'h00, 10'h301, 10'h000},  // R2 ch8, ch9
        {4'd3,  OP_RD,  8'hB8, 10'h000, 10'h003},  // R3
        {4'd9,  OP_WR,  8'hB9, 10'h0FF, 10'h000},  // R9
        {4'd9,  OP_RD,  8'hB9, 10'h000, 10'h003},  // R9
        {4'd4,  OP_IRQ, 8'h00, 10'h000, 10'h301},  // R4
        {4'd7,  OP_RMW, 8'h40, 10'h000, 10'h0FF},  // R7
        {4'd6,  OP_WR,  8'h40, 10'h0FE, 10'h000},  // R6
        {4'd6,  OP_RD,  8'h40, 10'h000, 10'h000},  // R6
        {4'd6,  OP_IRQ, 8'h00, 10'h000, 10'h300},  // R6
        {4'd6,  OP_WR,  8'hB8, 10'h0FF, 10'h000},  // R6 ones ignored
        {4'd6,  OP_RD,  8'hB8, 10'h000, 10'h003},  // R6
        {4'd6,  OP_WR,  8'hB8, 10'h0FD, 10'h000},  // R6 clear ch9
        {4'd6,  OP_RD,  8'hB8, 10'h000, 10'h001},  // R6
        {4'd2,  OP_PIN, 8'h00, 10'h000, 10'h000},  // R2 all low
        {4'd2,  OP_PIN, 8'h00, 10'h0FE, 10'h000},  // R2 ch1..7
        {4'd3,  OP_RD,  8'h40, 10'h000, 10'h0FE},  // R3
        {4'd5,  OP_IRQ, 8'h00, 10'h000, 10'h100},  // R5
        {4'd4,  OP_WR,  8'h41, 10'h0FF, 10'h000},  // R4
        {4'd4,  OP_IRQ, 8'h00, 10'h000, 10'h1FE},  // R4
        {4'd7,  OP_RMW, 8'hB8, 10'h000, 10'h0FF},  // R7
        {4'd9,  OP_RD,  8'h55, 10'h000, 10'h000}   // R9 unmapped
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] irq_pin = '0;
    logic       nmi_pin = 1'b0;
    logic       nmi_ack = 1'b0;
    logic [7:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic       rmw = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [9:0] irq_req;
    logic       nmi_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pin_i   (irq_pin),
        .nmi_pin_i   (nmi_pin),
        .nmi_ack_i   (nmi_ack),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_rmw_i   (rmw),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_req_o   (irq_req),
        .nmi_req_o   (nmi_req)
    );

    task automatic check(input int req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic m, input int req, input logic [7:0] e);
        @(negedge clk);
        addr = a; rd = 1'b1; rmw = m;
        #1;
        check(req, {2'b00, rdata}, {2'b00, e});
        rd = 1'b0; rmw = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 10000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(1, irq_req, 10'h000);             // R1
        check(1, {9'd0, nmi_req}, 10'h000);     // R1

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq;
            logic [2:0] op;
            logic [7:0] va;
            logic [9:0] vd;
            logic [9:0] ve;
            {rq, op, va, vd, ve} = VEC[i];
            case (op)
                OP_WR:  bus_write(va, vd[7:0]);
                OP_RD:  bus_read(va, 1'b0, int'(rq), ve[7:0]);
                OP_RMW: bus_read(va, 1'b1, int'(rq), ve[7:0]);
                OP_PIN: begin
                    @(negedge clk);
                    irq_pin = vd;
                    settle();
                end
                default: begin
                    @(negedge clk);
                    #1;
                    check(int'(rq), irq_req, ve);
                end
            endcase
        end

        // R2: held-high pin does not re-set a cleared flag
        bus_write(8'h40, 8'h00);
        settle();
        bus_read(8'h40, 1'b0, 2, 8'h00);

        // R8: edge set and clear-by-write land on the same edge
        @(negedge clk);
        irq_pin = '0;
        settle();
        @(negedge clk);
        irq_pin[2] = 1'b1;
        @(negedge clk);
        bus_write(8'h40, 8'h00);
        bus_read(8'h40, 1'b0, 8, 8'h04);

        // R10: non-maskable latch, bus has no reach, ack clears
        @(negedge clk);
        nmi_pin = 1'b1;
        settle();
        check(10, {9'd0, nmi_req}, 10'h001);
        bus_write(8'h40, 8'h00);
        bus_write(8'hB8, 8'h00);
        bus_write(8'h41, 8'h00);
        #1;
        check(10, {9'd0, nmi_req}, 10'h001);
        bus_read(8'h40, 1'b0, 10, 8'h00);
        bus_read(8'hB8, 1'b0, 10, 8'h00);
        @(negedge clk);
        nmi_ack = 1'b1;
        @(negedge clk);
        nmi_ack = 1'b0;
        #1;
        check(10, {9'd0, nmi_req}, 10'h000);

        // R9: no read strobe means zero data
        @(negedge clk);
        addr = 8'h41; rd = 1'b0;
        #1;
        check(9, {2'b00, rdata}, 10'h000);

        // R1: reset mid-run clears enables and flags
        @(negedge clk);
        irq_pin = 10'h3FF;
        settle();
        bus_write(8'h41, 8'hFF);
        bus_write(8'hB9, 8'h03);
        @(negedge clk);
        rst_n = 1'b0;
        irq_pin = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(1, irq_req, 10'h000);
        bus_read(8'h41, 1'b0, 1, 8'h00);
        bus_read(8'hB9, 1'b0, 1, 8'h00);
        bus_read(8'h40, 1'b0, 1, 8'h00);
        bus_read(8'hB8, 1'b0, 1, 8'h00);

        finish_run();
    end
endmodule